// File: doc/BRIEF.md
# Programmable-Latency RAM Read Sequencer

This block paces single read accesses to a tag RAM and a data RAM whose access times are chosen by software. A requester raises a valid signal while the sequencer is idle; on that clock edge the sequencer captures the two latency codes and the mux-mode bit, goes busy and starts counting cycles. When the tag RAM result is due it pulses a tag strobe. When the data RAM result has passed through the output read multiplexer it pulses a data strobe. Downstream logic uses these strobes to capture the RAM outputs.

Latency codes are not plain counts. The 3-bit tag code and the 4-bit data code each go through a small decode that clamps at both ends. The mux-mode bit adds one or two further cycles on top of the data latency. Only one access is in flight at a time, and the requester is held off until both strobes have been issued.

Top module: `ram_rd_seq`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `tag_done` and `data_done` are 0 and `req_ready` is 1.
- R2: The tag delay T decodes from `tag_lat_code` as follows: codes 0 and 1 give 2 cycles, code 2 gives 3 cycles, and codes 3 to 7 give 4 cycles.
- R3: The data RAM delay D decodes from `data_lat_code` as follows: codes 0 and 1 give 2 cycles, and codes 2 to 12 give the code value plus one (3 to 13 cycles).
- R4: Data codes 13, 14 and 15 all clamp to a data RAM delay of 13 cycles.
- R5: The mux stage adds M cycles: M = 2 when `mux_one_cycle` is 0 and M = 1 when it is 1. Calling the first cycle after the accepting edge cycle 1, `data_done` is high for exactly one cycle, in cycle D+M.
- R6: Counting the same way, `tag_done` is high for exactly one cycle, in cycle T.
- R7: The codes and the mode bit are captured at acceptance. Changing them while busy has no effect on the strobes of the access in progress.
- R8: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. While busy, `req_ready` is 0 and `req_valid` is ignored.
- R9: `busy` is high from cycle 1 through cycle L, where L = max(T, D+M). `req_ready` returns to 1 in cycle L+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Sequencer can accept a request |
| tag_lat_code | input | 3 | Tag RAM latency code |
| data_lat_code | input | 4 | Data RAM latency code |
| mux_one_cycle | input | 1 | 1: one-cycle mux select, 0: two-cycle |
| tag_done | output | 1 | Tag result capture strobe |
| data_done | output | 1 | Data result capture strobe |
| busy | output | 1 | Access in progress |

## Verification
The hardest case to reach is an access where the tag strobe comes after the data strobe. This happens only with a short data code, the one-cycle mux mode and a tag code of 3 or more, and in that case the release of `busy` must follow the tag strobe. Directed sweeps cover every tag code and every data code in both mux modes, and every data code is paired with the slowest tag code to force this ordering. Random accesses then keep `req_valid` high and scramble the codes on every busy cycle, which checks that the captured values and the idle-only handshake hold.

// File: rtl/ram_rd_seq.sv
module ram_rd_seq #(
  parameter int TAG_CODE_W  = 3,
  parameter int DATA_CODE_W = 4,
  parameter int TAG_MIN     = 2,
  parameter int TAG_MAX     = 4,
  parameter int DATA_MIN    = 2,
  parameter int DATA_MAX    = 13
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [TAG_CODE_W-1:0]  tag_lat_code,
  input  logic [DATA_CODE_W-1:0] data_lat_code,
  input  logic                   mux_one_cycle,
  output logic                   tag_done,
  output logic                   data_done,
  output logic                   busy
);
  localparam int TOT_MAX = DATA_MAX + 2;
  localparam int CNT_W   = $clog2(TOT_MAX + 2);

  function automatic logic [CNT_W-1:0] tag_decode(input logic [TAG_CODE_W-1:0] c);
    int v;
    v = int'(c) + 1;
    if (v < TAG_MIN) v = TAG_MIN;
    if (v > TAG_MAX) v = TAG_MAX;
    return CNT_W'(v);
  endfunction

  function automatic logic [CNT_W-1:0] data_decode(input logic [DATA_CODE_W-1:0] c,
                                                   input logic one);
    int v;
    v = int'(c) + 1;
    if (v < DATA_MIN) v = DATA_MIN;
    if (v > DATA_MAX) v = DATA_MAX;
    return CNT_W'(v + (one ? 1 : 2));
  endfunction

  logic [CNT_W-1:0] cnt, tag_due, data_due;
  logic [CNT_W-1:0] last_due;
  logic             accept;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign last_due  = (tag_due > data_due) ? tag_due : data_due;
  assign tag_done  = busy && (cnt == tag_due);
  assign data_done = busy && (cnt == data_due);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      tag_due  <= '0;
      data_due <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      cnt      <= CNT_W'(1);
      tag_due  <= tag_decode(tag_lat_code);
      data_due <= data_decode(data_lat_code, mux_one_cycle);
    end else if (busy) begin
      if (cnt == last_due) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  a_r6_tag_single: assert property (@(posedge clk) disable iff (rst)
    tag_done |=> !tag_done);
  a_r5_data_single: assert property (@(posedge clk) disable iff (rst)
    data_done |=> !data_done);
  a_r2_tag_window: assert property (@(posedge clk) disable iff (rst)
    tag_done |-> (cnt >= CNT_W'(TAG_MIN)) && (cnt <= CNT_W'(TAG_MAX)));
  a_r4_data_window: assert property (@(posedge clk) disable iff (rst)
    data_done |-> (cnt >= CNT_W'(DATA_MIN + 1)) && (cnt <= CNT_W'(TOT_MAX)));
  a_r9_release_after_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tag_done || data_done));
  a_r7_hold_codes: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(tag_due) && $stable(data_due)));
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !(cnt == last_due)) |=> busy && (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: tb/ram_rd_seq_test.sv
module ram_rd_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] tag_lat_code = '0;
  logic [3:0] data_lat_code = '0;
  logic       mux_one_cycle = 1'b0;
  logic       tag_done, data_done, busy;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  ram_rd_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .tag_lat_code(tag_lat_code), .data_lat_code(data_lat_code),
    .mux_one_cycle(mux_one_cycle), .tag_done(tag_done),
    .data_done(data_done), .busy(busy)
  );

  function automatic int exp_tag(input int c);
    if (c <= 1) return 2;
    if (c == 2) return 3;
    return 4;
  endfunction

  function automatic int exp_data(input int c);
    if (c <= 1) return 2;
    if (c >= 12) return 13;
    return c + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic access(input int tc, input int dc, input bit one, input bit scramble);
    int t, d, l;
    t = exp_tag(tc);
    d = exp_data(dc) + (one ? 1 : 2);
    l = (t > d) ? t : d;
    @(negedge clk);
    check(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    tag_lat_code = 3'(tc);
    data_lat_code = 4'(dc);
    mux_one_cycle = one;
    for (int n = 1; n <= l + 1; n++) begin
      @(negedge clk);
      check(tag_done == (n == t), (dc >= 13) ? "R6 tag strobe (R4 code)" : "R6 R2 tag strobe",
            int'(tag_done), int'(n == t));
      check(data_done == (n == d), (dc >= 13) ? "R4 R5 data strobe" : "R3 R5 data strobe",
            int'(data_done), int'(n == d));
      check(busy == (n <= l), "R9 busy window", int'(busy), int'(n <= l));
      check(req_ready == (n > l), "R8 R9 ready", int'(req_ready), int'(n > l));
      if (n <= l && scramble) begin
        req_valid = 1'b1;
        tag_lat_code = 3'($urandom);
        data_lat_code = 4'($urandom);
        mux_one_cycle = 1'($urandom);
      end else begin
        req_valid = (n <= l);
      end
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(tag_done == 1'b0 && data_done == 1'b0, "R1 strobes after reset",
          int'({tag_done, data_done}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1 idle with no request", int'(busy), 0);
    for (int tc = 0; tc < 8; tc++) access(tc, 5, 1'b0, 1'b0);
    for (int m = 0; m < 2; m++)
      for (int dc = 0; dc < 16; dc++) access(0, dc, 1'(m), 1'b0);
    for (int dc = 0; dc < 16; dc++) access(7, dc, 1'b1, 1'b0);
    for (int i = 0; i < 300; i++)
      access(int'($urandom_range(7, 0)), int'($urandom_range(15, 0)), 1'($urandom), 1'b1);
    @(negedge clk);
    check(busy == 1'b0, "R8 idle after last access", int'(busy), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule